// File: doc/BRIEF.md
# Issue Queue Entry State Tracker

This block keeps the bookkeeping of a small out-of-order issue queue. Each entry holds one dispatched instruction and walks it through four states: waiting (some operand latency still unknown), pending (all latencies known but the instruction cannot yet issue), ready (register operands available and memory ordering satisfied), and executing (issued, awaiting write-back). Per-entry event masks arrive every cycle. They say that latencies became known, operands arrived, memory ordering cleared, the selector issued an entry, or write-back finished. The tracker folds these into sticky per-entry flags and promotes entries.

Dispatch presents one instruction per cycle with its readiness flags and load/store kind. The tracker either places it in the lowest-numbered free entry or refuses it with a status code. A refusal caused by a lack of queue, load-queue or store-queue space raises a one-cycle token-stall indication. An accepted instruction that has zero latency, or that carries a force-issue flag, is flagged for immediate issue. The selector reads the ready mask. Per-entry event pulses report which entries passed through pending, which reached ready and which retired.

Top module: `iq_state_tracker`

## Requirements
- R1: After reset every entry is invalid, the token-stall flag is 0 and the dispatch status reads 0 (available) while no dispatch is presented.
- R2: An accepted dispatch takes the lowest-numbered invalid entry, shown combinationally on the slot output. That entry is valid from the next clock edge.
- R3: Per-entry state is shown on bits [2i+1:2i] of the state output, coded 0 wait, 1 pending, 2 ready, 3 executing. A dispatched entry starts ready if its operands are available and its memory ordering is clear. It starts pending if its latencies are known, or its operands are available while memory ordering is still outstanding. It starts in wait otherwise.
- R4: A waiting entry whose latency-known bit is seen moves to pending and pulses its pending-event bit for one cycle after the edge.
- R5: A waiting entry whose flags make it fully ready in the same cycle that its latencies become known goes straight to ready. It pulses both its pending-event and ready-event bits.
- R6: Operand and memory flags accumulate across cycles. A pending entry moves to ready and pulses its ready-event bit only once both are set. Operands alone leave it pending.
- R7: An issue bit moves a ready entry to executing. An issue bit on an entry in any other state has no effect. A valid entry's state never moves backwards.
- R8: A write-back bit on an executing entry frees it and pulses its done-event bit. A write-back bit on an entry in any other state has no effect.
- R9: The status output is combinational. The codes are 0 available, 1 load queue full, 2 store queue full, 3 buffers full and 4 dispatch group stall. The priority is: no free entry, then a load with its queue full, then a store with its queue full, then group stall. A dispatch is accepted only with code 0.
- R10: The token-stall flag is 1 in the cycle after a dispatch is refused with code 1, 2 or 3. In any other cycle it is 0, and a group-stall refusal does not set it.
- R11: The immediate-issue output is high, in the same cycle, for an accepted dispatch that is zero-latency or force-issue. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid_i | input | 1 | Dispatch request this cycle |
| disp_ops_rdy_i | input | 1 | All register operands already available |
| disp_lat_known_i | input | 1 | All operand latencies known |
| disp_mem_ok_i | input | 1 | No outstanding memory ordering dependency |
| disp_is_load_i | input | 1 | Instruction needs a load-queue slot |
| disp_is_store_i | input | 1 | Instruction needs a store-queue slot |
| disp_zero_lat_i | input | 1 | Instruction has zero latency |
| disp_force_issue_i | input | 1 | Instruction must issue at once |
| ldq_full_i | input | 1 | Load queue has no free slot |
| stq_full_i | input | 1 | Store queue has no free slot |
| grp_stall_i | input | 1 | Dispatch group cannot be completed |
| lat_known_i | input | N_ENTRIES | Per-entry latencies-known event |
| ops_rdy_i | input | N_ENTRIES | Per-entry operands-available event |
| mem_ok_i | input | N_ENTRIES | Per-entry memory-ordering-cleared event |
| issue_i | input | N_ENTRIES | Per-entry issue from the selector |
| wb_i | input | N_ENTRIES | Per-entry write-back completion |
| disp_accept_o | output | 1 | Dispatch accepted this cycle |
| disp_slot_o | output | IDX_W | Lowest free entry index |
| disp_status_o | output | 3 | Dispatch status code |
| disp_imm_o | output | 1 | Accepted instruction must issue immediately |
| tok_stall_o | output | 1 | Previous cycle refused dispatch for lack of resources |
| valid_o | output | N_ENTRIES | Entry occupied |
| ready_o | output | N_ENTRIES | Entry valid and in ready state |
| state_o | output | 2*N_ENTRIES | Per-entry state code |
| pend_evt_o | output | N_ENTRIES | Entry entered pending in the last cycle |
| ready_evt_o | output | N_ENTRIES | Entry entered ready in the last cycle |
| done_evt_o | output | N_ENTRIES | Entry retired in the last cycle |

## Verification
The embedded properties assume well-behaved neighbours. The selector raises an issue bit only for entries it saw in the ready mask, and write-back comes only for entries that were issued. The stimulus, however, also drives issue and write-back bits at entries in the wrong state, to show they are ignored. The properties on forward-only state movement hold regardless. Event bits are never aimed at invalid entries. An entry is never dispatched in the cycle it retires, because allocation looks only at entries already invalid. Load and store full flags are driven only together with a dispatch request, so each status code is tied to one known cause.

// File: rtl/iq_pkg.sv
package iq_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_PEND = 2'd1,
    ST_RDY  = 2'd2,
    ST_EXEC = 2'd3
  } iq_state_e;

  typedef enum logic [2:0] {
    DS_OK   = 3'd0,
    DS_LDQ  = 3'd1,
    DS_STQ  = 3'd2,
    DS_FULL = 3'd3,
    DS_GRP  = 3'd4
  } disp_stat_e;

endpackage

// File: rtl/iq_slot_alloc.sv
module iq_slot_alloc #(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = 3
) (
  input  logic [N_ENTRIES-1:0] valid_i,
  output logic                 any_free_o,
  output logic [IDX_W-1:0]     free_idx_o
);

  // Scan from the top so the lowest free index wins.
  always_comb begin
    any_free_o = 1'b0;
    free_idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        any_free_o = 1'b1;
        free_idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/iq_disp_ctrl.sv
module iq_disp_ctrl
  import iq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       disp_valid_i,
  input  logic       is_load_i,
  input  logic       is_store_i,
  input  logic       zero_lat_i,
  input  logic       force_issue_i,
  input  logic       ldq_full_i,
  input  logic       stq_full_i,
  input  logic       grp_stall_i,
  input  logic       any_free_i,
  output logic       accept_o,
  output logic [2:0] status_o,
  output logic       imm_o,
  output logic       tok_stall_o
);

  disp_stat_e stat;
  logic       res_refuse;
  logic       tok_d, tok_q;

  // Priority: queue space, load queue, store queue, group completion.
  always_comb begin
    stat = DS_OK;
    if (disp_valid_i) begin
      if (!any_free_i)                  stat = DS_FULL;
      else if (is_load_i && ldq_full_i) stat = DS_LDQ;
      else if (is_store_i && stq_full_i) stat = DS_STQ;
      else if (grp_stall_i)             stat = DS_GRP;
    end
  end

  assign status_o   = stat;
  assign accept_o   = disp_valid_i && (stat == DS_OK);
  assign imm_o      = accept_o && (zero_lat_i || force_issue_i);
  assign res_refuse = (stat == DS_LDQ) || (stat == DS_STQ) || (stat == DS_FULL);
  assign tok_d      = disp_valid_i && res_refuse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= 1'b0;
    else        tok_q <= tok_d;
  end

  assign tok_stall_o = tok_q;

  // R10: resource refusal shows as token stall one cycle later
  p_tok_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_i && (status_o == 3'd1 || status_o == 3'd2 || status_o == 3'd3))
      |=> tok_stall_o);

  // R10: group stall alone never raises token stall
  p_grp_no_tok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_i && status_o == 3'd4) |=> !tok_stall_o);

  // R11: immediate issue only accompanies an accepted dispatch
  p_imm_acc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    imm_o |-> accept_o);

endmodule

// File: rtl/iq_entry.sv
module iq_entry
  import iq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alloc_i,
  input  logic       a_ops_i,
  input  logic       a_lat_i,
  input  logic       a_mem_i,
  input  logic       lat_i,
  input  logic       ops_i,
  input  logic       mem_i,
  input  logic       issue_i,
  input  logic       wb_i,
  output logic       valid_o,
  output logic [1:0] state_o,
  output logic       pend_evt_o,
  output logic       ready_evt_o,
  output logic       done_evt_o
);

  logic      valid_q, valid_d;
  iq_state_e st_q, st_d;
  logic      lat_q, lat_d, ops_q, ops_d, mem_q, mem_d;
  logic      pev_d, rev_d, dev_d;
  logic      pev_q, rev_q, dev_q;
  logic      opnd_ok;
  logic      upd_en;

  assign upd_en = alloc_i || valid_q;

  // Next-state: fold this cycle's events into the sticky flags, then promote.
  always_comb begin
    valid_d = valid_q;
    st_d    = st_q;
    lat_d   = lat_q;
    ops_d   = ops_q;
    mem_d   = mem_q;
    pev_d   = 1'b0;
    rev_d   = 1'b0;
    dev_d   = 1'b0;
    opnd_ok = 1'b0;
    if (alloc_i) begin
      valid_d = 1'b1;
      ops_d   = a_ops_i;
      lat_d   = a_lat_i || a_ops_i;
      mem_d   = a_mem_i;
      if (a_ops_i && a_mem_i)      st_d = ST_RDY;
      else if (a_lat_i || a_ops_i) st_d = ST_PEND;
      else                         st_d = ST_WAIT;
    end else if (valid_q) begin
      ops_d   = ops_q || ops_i;
      lat_d   = lat_q || lat_i || ops_d;
      mem_d   = mem_q || mem_i;
      opnd_ok = ops_d && mem_d;
      unique case (st_q)
        ST_WAIT: begin
          if (lat_d) begin
            pev_d = 1'b1;
            if (opnd_ok) begin
              st_d  = ST_RDY;
              rev_d = 1'b1;
            end else begin
              st_d = ST_PEND;
            end
          end
        end
        ST_PEND: begin
          if (opnd_ok) begin
            st_d  = ST_RDY;
            rev_d = 1'b1;
          end
        end
        ST_RDY: begin
          if (issue_i) st_d = ST_EXEC;
        end
        ST_EXEC: begin
          if (wb_i) begin
            valid_d = 1'b0;
            dev_d   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      st_q    <= ST_WAIT;
      lat_q   <= 1'b0;
      ops_q   <= 1'b0;
      mem_q   <= 1'b0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      st_q    <= st_d;
      lat_q   <= lat_d;
      ops_q   <= ops_d;
      mem_q   <= mem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pev_q <= 1'b0;
      rev_q <= 1'b0;
      dev_q <= 1'b0;
    end else begin
      pev_q <= pev_d;
      rev_q <= rev_d;
      dev_q <= dev_d;
    end
  end

  assign valid_o     = valid_q;
  assign state_o     = st_q;
  assign pend_evt_o  = pev_q;
  assign ready_evt_o = rev_q;
  assign done_evt_o  = dev_q;

  // R7: a live entry never steps back to an earlier state
  p_no_backward_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(valid_q)) |-> (st_q >= $past(st_q)));

  // R7: executing is entered only from ready under an issue bit
  p_exec_from_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && st_q == ST_EXEC && $past(valid_q) && $past(st_q) != ST_EXEC)
      |-> ($past(st_q) == ST_RDY && $past(issue_i)));

  // R8: a done pulse follows an executing entry that has now gone
  p_done_from_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt_o |-> ($past(valid_q) && $past(st_q) == ST_EXEC && !valid_q));

  // R5: a ready pulse out of wait always comes with a pending pulse
  p_wait_to_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_evt_o && $past(st_q) == ST_WAIT) |-> pend_evt_o);

endmodule

// File: rtl/iq_state_tracker.sv
module iq_state_tracker
  import iq_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid_i,
  input  logic                   disp_ops_rdy_i,
  input  logic                   disp_lat_known_i,
  input  logic                   disp_mem_ok_i,
  input  logic                   disp_is_load_i,
  input  logic                   disp_is_store_i,
  input  logic                   disp_zero_lat_i,
  input  logic                   disp_force_issue_i,
  input  logic                   ldq_full_i,
  input  logic                   stq_full_i,
  input  logic                   grp_stall_i,
  input  logic [N_ENTRIES-1:0]   lat_known_i,
  input  logic [N_ENTRIES-1:0]   ops_rdy_i,
  input  logic [N_ENTRIES-1:0]   mem_ok_i,
  input  logic [N_ENTRIES-1:0]   issue_i,
  input  logic [N_ENTRIES-1:0]   wb_i,
  output logic                   disp_accept_o,
  output logic [IDX_W-1:0]       disp_slot_o,
  output logic [2:0]             disp_status_o,
  output logic                   disp_imm_o,
  output logic                   tok_stall_o,
  output logic [N_ENTRIES-1:0]   valid_o,
  output logic [N_ENTRIES-1:0]   ready_o,
  output logic [2*N_ENTRIES-1:0] state_o,
  output logic [N_ENTRIES-1:0]   pend_evt_o,
  output logic [N_ENTRIES-1:0]   ready_evt_o,
  output logic [N_ENTRIES-1:0]   done_evt_o
);

  logic [N_ENTRIES-1:0] valid_w;
  logic                 any_free;
  logic [IDX_W-1:0]     free_idx;
  logic                 accept;

  iq_slot_alloc #(
    .N_ENTRIES (N_ENTRIES),
    .IDX_W     (IDX_W)
  ) u_alloc (
    .valid_i    (valid_w),
    .any_free_o (any_free),
    .free_idx_o (free_idx)
  );

  iq_disp_ctrl u_disp (
    .clk           (clk),
    .rst_n         (rst_n),
    .disp_valid_i  (disp_valid_i),
    .is_load_i     (disp_is_load_i),
    .is_store_i    (disp_is_store_i),
    .zero_lat_i    (disp_zero_lat_i),
    .force_issue_i (disp_force_issue_i),
    .ldq_full_i    (ldq_full_i),
    .stq_full_i    (stq_full_i),
    .grp_stall_i   (grp_stall_i),
    .any_free_i    (any_free),
    .accept_o      (accept),
    .status_o      (disp_status_o),
    .imm_o         (disp_imm_o),
    .tok_stall_o   (tok_stall_o)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic [1:0] st;
    iq_entry u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (accept && (free_idx == IDX_W'(g))),
      .a_ops_i     (disp_ops_rdy_i),
      .a_lat_i     (disp_lat_known_i),
      .a_mem_i     (disp_mem_ok_i),
      .lat_i       (lat_known_i[g]),
      .ops_i       (ops_rdy_i[g]),
      .mem_i       (mem_ok_i[g]),
      .issue_i     (issue_i[g]),
      .wb_i        (wb_i[g]),
      .valid_o     (valid_w[g]),
      .state_o     (st),
      .pend_evt_o  (pend_evt_o[g]),
      .ready_evt_o (ready_evt_o[g]),
      .done_evt_o  (done_evt_o[g])
    );
    assign state_o[2*g +: 2] = st;
    assign ready_o[g]        = valid_w[g] && (st == ST_RDY);
  end

  assign valid_o       = valid_w;
  assign disp_accept_o = accept;
  assign disp_slot_o   = free_idx;

  // R9: a full queue refuses every dispatch with the buffers-full code
  p_full_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_i && (&valid_w)) |-> (disp_status_o == 3'd3 && !disp_accept_o));

  // R2: an accepted dispatch targets an empty entry
  p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_accept_o |-> !valid_w[disp_slot_o]);

  // R2: the targeted entry is occupied after the edge
  p_alloc_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_accept_o |=> valid_w[$past(disp_slot_o)]);

endmodule

// File: tb/iq_state_tracker_tb_top.sv
module iq_state_tracker_tb_top;

  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int IW    = 3;

  localparam int SG_VALID = 0, SG_READY = 1, SG_STATE = 2, SG_PEV = 3, SG_REV = 4,
                 SG_DEV = 5, SG_ACC = 6, SG_SLOT = 7, SG_STAT = 8, SG_IMM = 9, SG_TOK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid, d_ops, d_lat, d_mem, d_ld, d_st, d_zl, d_fi;
  logic ldq_full, stq_full, grp_stall;
  logic [N-1:0] lat_known, ops_rdy, mem_ok, issue, wb;
  logic accept, imm, tok;
  logic [IW-1:0] slot;
  logic [2:0] status;
  logic [N-1:0] valid, ready, pev, rev, dev;
  logic [2*N-1:0] state;

  always #(CLK_P/2) clk = ~clk;

  iq_state_tracker #(.N_ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid_i(disp_valid), .disp_ops_rdy_i(d_ops), .disp_lat_known_i(d_lat),
    .disp_mem_ok_i(d_mem), .disp_is_load_i(d_ld), .disp_is_store_i(d_st),
    .disp_zero_lat_i(d_zl), .disp_force_issue_i(d_fi),
    .ldq_full_i(ldq_full), .stq_full_i(stq_full), .grp_stall_i(grp_stall),
    .lat_known_i(lat_known), .ops_rdy_i(ops_rdy), .mem_ok_i(mem_ok),
    .issue_i(issue), .wb_i(wb),
    .disp_accept_o(accept), .disp_slot_o(slot), .disp_status_o(status),
    .disp_imm_o(imm), .tok_stall_o(tok),
    .valid_o(valid), .ready_o(ready), .state_o(state),
    .pend_evt_o(pev), .ready_evt_o(rev), .done_evt_o(dev)
  );

  typedef struct {
    int    cyc;
    int    sig;
    int    idx;
    int    exp;
    string tag;
  } item_t;

  item_t sb[$];
  int    cyc    = 0;
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  function automatic int obs(int sig, int idx);
    case (sig)
      SG_VALID: return int'(valid);
      SG_READY: return int'(ready);
      SG_STATE: return int'(state[2*idx +: 2]);
      SG_PEV:   return int'(pev);
      SG_REV:   return int'(rev);
      SG_DEV:   return int'(dev);
      SG_ACC:   return int'(accept);
      SG_SLOT:  return int'(slot);
      SG_STAT:  return int'(status);
      SG_IMM:   return int'(imm);
      SG_TOK:   return int'(tok);
      default:  return -1;
    endcase
  endfunction

  // Driver side: queue an expectation for the sample dly cycles ahead.
  task automatic expect_at(int dly, int sig, int idx, int exp, string tag);
    item_t it;
    it.cyc = cyc + dly;
    it.sig = sig;
    it.idx = idx;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: samples just before each rising edge and drains due items.
  always @(negedge clk) begin
    #(CLK_P/2 - 1);
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item_t it;
      int act;
      it  = sb.pop_front();
      act = obs(it.sig, it.idx);
      n_run++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s sig=%0d idx=%0d actual=%0h expected=%0h",
                 it.tag, it.sig, it.idx, act, it.exp);
      end
    end
    cyc++;
  end

  task automatic nxt();
    @(negedge clk);
    #1;
    disp_valid = 0; d_ops = 0; d_lat = 0; d_mem = 0; d_ld = 0; d_st = 0;
    d_zl = 0; d_fi = 0; ldq_full = 0; stq_full = 0; grp_stall = 0;
    lat_known = '0; ops_rdy = '0; mem_ok = '0; issue = '0; wb = '0;
  endtask

  task automatic disp(logic ops, logic lat, logic mem);
    disp_valid = 1; d_ops = ops; d_lat = lat; d_mem = mem;
  endtask

  initial begin
    disp_valid = 0; d_ops = 0; d_lat = 0; d_mem = 0; d_ld = 0; d_st = 0;
    d_zl = 0; d_fi = 0; ldq_full = 0; stq_full = 0; grp_stall = 0;
    lat_known = '0; ops_rdy = '0; mem_ok = '0; issue = '0; wb = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_at(0, SG_VALID, 0, 0, "R1 valid");
    expect_at(0, SG_TOK, 0, 0, "R1 tok");
    expect_at(0, SG_STAT, 0, 0, "R1 status");
    nxt();
    // c1: wait-class instruction into entry 0
    disp(0, 0, 1);
    expect_at(0, SG_ACC, 0, 1, "R2 accept");
    expect_at(0, SG_SLOT, 0, 0, "R2 slot0");
    expect_at(0, SG_STAT, 0, 0, "R9 available");
    expect_at(1, SG_STATE, 0, 0, "R3 wait");
    expect_at(1, SG_VALID, 0, 'h01, "R2 valid");
    nxt();
    disp(0, 1, 1);
    expect_at(0, SG_SLOT, 0, 1, "R2 slot1");
    expect_at(1, SG_STATE, 1, 1, "R3 pend by latency");
    nxt();
    disp(1, 0, 0);
    expect_at(0, SG_SLOT, 0, 2, "R2 slot2");
    expect_at(1, SG_STATE, 2, 1, "R3 pend on memory");
    nxt();
    disp(1, 0, 1); d_zl = 1;
    expect_at(0, SG_SLOT, 0, 3, "R2 slot3");
    expect_at(0, SG_IMM, 0, 1, "R11 zero latency");
    expect_at(1, SG_STATE, 3, 2, "R3 ready");
    expect_at(1, SG_VALID, 0, 'h0F, "R2 valid");
    nxt();
    disp(0, 0, 1);
    lat_known = 8'h01;
    expect_at(0, SG_IMM, 0, 0, "R11 no imm");
    expect_at(1, SG_STATE, 0, 1, "R4 wait to pend");
    expect_at(1, SG_PEV, 0, 'h01, "R4 pend event");
    expect_at(1, SG_REV, 0, 'h00, "R4 no ready event");
    expect_at(1, SG_STATE, 4, 0, "R3 wait slot4");
    nxt();
    lat_known = 8'h10; ops_rdy = 8'h10;
    disp(0, 1, 0); d_fi = 1;
    expect_at(0, SG_SLOT, 0, 5, "R2 slot5");
    expect_at(0, SG_IMM, 0, 1, "R11 force issue");
    expect_at(1, SG_STATE, 4, 2, "R5 wait to ready");
    expect_at(1, SG_PEV, 0, 'h10, "R5 pend event");
    expect_at(1, SG_REV, 0, 'h10, "R5 ready event");
    expect_at(1, SG_STATE, 5, 1, "R3 pend slot5");
    nxt();
    ops_rdy = 8'h21;
    expect_at(1, SG_STATE, 0, 2, "R6 pend to ready");
    expect_at(1, SG_REV, 0, 'h01, "R6 ready event");
    expect_at(1, SG_STATE, 5, 1, "R6 operands alone");
    nxt();
    mem_ok = 8'h20;
    expect_at(1, SG_STATE, 5, 2, "R6 accumulated");
    expect_at(1, SG_REV, 0, 'h20, "R6 ready event slot5");
    nxt();
    expect_at(0, SG_READY, 0, 'h39, "R7 ready mask");
    issue = 8'h0A;
    expect_at(1, SG_STATE, 3, 3, "R7 issue");
    expect_at(1, SG_STATE, 1, 1, "R7 issue ignored");
    expect_at(1, SG_READY, 0, 'h31, "R7 ready mask after");
    nxt();
    wb = 8'h09;
    expect_at(1, SG_DEV, 0, 'h08, "R8 done event");
    expect_at(1, SG_STATE, 0, 2, "R8 wb ignored");
    expect_at(1, SG_VALID, 0, 'h37, "R8 freed");
    nxt();
    disp(1, 0, 1); d_ld = 1; ldq_full = 1;
    expect_at(0, SG_STAT, 0, 1, "R9 load full");
    expect_at(0, SG_ACC, 0, 0, "R9 refused");
    expect_at(0, SG_SLOT, 0, 3, "R2 reuse lowest");
    expect_at(1, SG_TOK, 0, 1, "R10 set by load");
    expect_at(1, SG_VALID, 0, 'h37, "R9 no alloc");
    nxt();
    disp(1, 0, 1); d_st = 1; stq_full = 1;
    expect_at(0, SG_STAT, 0, 2, "R9 store full");
    expect_at(1, SG_TOK, 0, 1, "R10 set by store");
    nxt();
    disp(1, 0, 1); grp_stall = 1;
    expect_at(0, SG_STAT, 0, 4, "R9 group stall");
    expect_at(0, SG_ACC, 0, 0, "R9 group refused");
    expect_at(1, SG_TOK, 0, 0, "R10 group no tok");
    nxt();
    disp(1, 0, 1); d_ld = 1;
    expect_at(0, SG_ACC, 0, 1, "R2 accept slot3");
    expect_at(1, SG_STATE, 3, 2, "R3 refill ready");
    nxt();
    disp(1, 0, 1);
    expect_at(0, SG_SLOT, 0, 6, "R2 slot6");
    nxt();
    disp(1, 0, 1);
    expect_at(0, SG_SLOT, 0, 7, "R2 slot7");
    expect_at(1, SG_VALID, 0, 'hFF, "R2 full");
    nxt();
    disp(1, 0, 1); d_ld = 1; ldq_full = 1; stq_full = 1;
    expect_at(0, SG_STAT, 0, 3, "R9 buffers full priority");
    expect_at(0, SG_ACC, 0, 0, "R9 full refused");
    expect_at(1, SG_TOK, 0, 1, "R10 set by full");
    nxt();
    expect_at(1, SG_TOK, 0, 0, "R10 clears");
    expect_at(1, SG_DEV, 0, 0, "R8 no done");
    nxt();
    repeat (3) nxt();
    wait (sb.size() == 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule